// File: doc/BRIEF.md
# Video Timing Mode Code Matcher

This block holds a small, writable table of supported video timings and, on request, finds the format code that belongs to a given timing. Each table entry carries a supported flag, a set of attribute flags (sync polarities and interlace), a packed timing word and a format code. The timing word has ten fields. Horizontal active, front porch, sync width and back porch come first. The same four vertical quantities follow, then pixel frequency and refresh rate. Setup logic fills the table through a write port. A separate disable port withdraws a single entry without erasing it, and an index lookup port reads any entry back.

A search starts with a one-cycle request while the block is idle. The query timing is captured at that moment. The block then examines one table entry per clock. The first pass looks for an entry whose whole timing word equals the query. If that pass finds nothing, a second pass looks only for equal active width and active height. The lowest-index hit of the pass that succeeds provides the code. If neither pass succeeds, a reserved all-ones code is reported as a miss. A busy flag covers the whole scan, and a one-cycle done pulse marks the result.

Top module: `vmode_match`

## Requirements
- R1: After reset, busy, done and hit are 0 and code is all ones; every table entry is unsupported, and its timing, flags and code are zero.
- R2: A cycle with wrEn high stores wrSupp, wrFlags, wrTiming and wrCode into entry wrIdx. The stored values are visible on the lookup outputs from the following cycle.
- R3: The lookup port is combinational. lkValid is 0 when lkIdx is DEPTH or more, or when the addressed entry is unsupported. For an out-of-range index, lkTiming, lkFlags and lkCode are zero. For an in-range index, they show the stored contents whether or not the entry is supported.
- R4: A cycle with disEn high clears the supported flag of entry disIdx and leaves its timing, flags and code unchanged. When disEn and wrEn hit the same entry in one cycle, the entry ends up unsupported.
- R5: The first pass matches an entry only when all ten timing fields are equal. Timing word layout from bit 0 upward: hAct, hFrontPorch, hSync, hBackPorch (HW bits each), vAct, vFrontPorch, vSync, vBackPorch (VW bits each), pixel frequency (FW bits), refresh rate (RW bits).
- R6: Entry attribute flags never take part in matching.
- R7: Within a pass, the lowest-index matching entry supplies the code.
- R8: The second pass runs only after the first pass finds nothing, and it compares hAct and vAct alone. An exact match at a higher index therefore wins over a size-only match at a lower index.
- R9: Unsupported entries never match in either pass.
- R10: When neither pass matches, done rises with hit = 0 and code = all ones.
- R11: A request is accepted at a clock edge where the block is idle. Busy is high from the next cycle until done. Done appears k+1 cycles after acceptance for a first-pass hit at entry k, DEPTH+k+1 cycles after for a second-pass hit at entry k, and 2*DEPTH cycles after for a miss.
- R12: A request raised while busy is ignored. The running search keeps its captured query and its timing, and no new search starts afterwards.
- R13: Done is a single-cycle pulse. Hit and code change only at the edge that raises done and hold until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Table write strobe |
| wrIdx | input | IDX_W | Entry written |
| wrSupp | input | 1 | Supported flag to store |
| wrFlags | input | FLG_W | Attribute flags to store (not matched) |
| wrTiming | input | TIM_W | Timing word to store |
| wrCode | input | CW | Format code to store |
| disEn | input | 1 | Disable strobe |
| disIdx | input | IDX_W | Entry to disable |
| lkIdx | input | IDX_W+1 | Lookup index (may exceed the table) |
| lkValid | output | 1 | Lookup entry exists and is supported |
| lkFlags | output | FLG_W | Lookup attribute flags |
| lkTiming | output | TIM_W | Lookup timing word |
| lkCode | output | CW | Lookup format code |
| req | input | 1 | Search request pulse |
| qryTiming | input | TIM_W | Timing to search for, captured on acceptance |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Last search found a code |
| code | output | CW | Last result code, all ones on a miss |

## Verification
The bench uses a table in which two entries share a full timing, a third shares only the active size, and one carries a timing that is present but unsupported. This tests lowest-index priority, exact-before-size precedence and the skipping of unsupported entries. A design that merged the two passes would return a size-only code where an exact one exists. A design that ignored the supported flag would report a hit where a miss is due. It also disables an entry and reads it back, which catches a disable that wipes the timing or leaves the entry matchable. Requests are injected in the middle of a scan, which catches a design that restarts or re-captures the query. Busy, done and result are compared on every cycle against a behavioural latency model, so an off-by-one in the scan length or in the pass turnover shows up as a wrong done cycle.

// File: rtl/vmode_match_pkg.sv
package vmode_match_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXACT = 2'd1,
    ST_SIZE  = 2'd2
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchQry;
    logic finHit;
    logic finMiss;
  } scanStrobe_t;

endpackage

// File: rtl/vmode_match_dp.sv
module vmode_match_dp
  import vmode_match_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int HW    = 12,
  parameter int VW    = 12,
  parameter int FW    = 16,
  parameter int RW    = 8,
  parameter int CW    = 8,
  parameter int FLG_W = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TIM_W = 4*HW + 4*VW + FW + RW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrSupp,
  input  logic [FLG_W-1:0]  wrFlags,
  input  logic [TIM_W-1:0]  wrTiming,
  input  logic [CW-1:0]     wrCode,
  input  logic              disEn,
  input  logic [IDX_W-1:0]  disIdx,
  input  logic [IDX_W:0]    lkIdx,
  output logic              lkValid,
  output logic [FLG_W-1:0]  lkFlags,
  output logic [TIM_W-1:0]  lkTiming,
  output logic [CW-1:0]     lkCode,
  input  logic [TIM_W-1:0]  qryTiming,
  input  scanStrobe_t       strb,
  input  logic [IDX_W-1:0]  scanIdx,
  output logic              exactHit,
  output logic              sizeHit,
  output logic              resHit,
  output logic [CW-1:0]     resCode
);

  localparam int VACT_LSB = 4*HW;
  localparam logic [CW-1:0] NO_CODE = '1;

  logic [DEPTH-1:0] entSupp;
  logic [FLG_W-1:0] entFlags [DEPTH];
  logic [TIM_W-1:0] entTim   [DEPTH];
  logic [CW-1:0]    entCode  [DEPTH];
  logic [DEPTH-1:0] wrSel, disSel;

  // per-entry decode of the write and disable ports
  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign wrSel[g]  = wrEn  && (wrIdx  == IDX_W'(g));
    assign disSel[g] = disEn && (disIdx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entSupp <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entFlags[i] <= '0;
        entTim[i]   <= '0;
        entCode[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wrSel[i]) begin
          entSupp[i]  <= wrSupp;
          entFlags[i] <= wrFlags;
          entTim[i]   <= wrTiming;
          entCode[i]  <= wrCode;
        end
        // disable overrides a same-cycle write to the same entry
        if (disSel[i]) entSupp[i] <= 1'b0;
      end
    end
  end

  // captured query
  logic [TIM_W-1:0] qTim;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              qTim <= '0;
    else if (strb.latchQry) qTim <= qryTiming;
  end

  // one shared comparator on the entry under scan
  logic [TIM_W-1:0] selTim;
  logic             selSupp;
  assign selTim  = entTim[scanIdx];
  assign selSupp = entSupp[scanIdx];
  assign exactHit = selSupp && (selTim == qTim);
  assign sizeHit  = selSupp
                 && (selTim[HW-1:0] == qTim[HW-1:0])
                 && (selTim[VACT_LSB +: VW] == qTim[VACT_LSB +: VW]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHit  <= 1'b0;
      resCode <= NO_CODE;
    end else if (strb.finHit) begin
      resHit  <= 1'b1;
      resCode <= entCode[scanIdx];
    end else if (strb.finMiss) begin
      resHit  <= 1'b0;
      resCode <= NO_CODE;
    end
  end

  // index lookup
  logic             lkInRange;
  logic [IDX_W-1:0] lkSel;
  assign lkInRange = lkIdx < (IDX_W+1)'(DEPTH);
  assign lkSel     = lkIdx[IDX_W-1:0];

  always_comb begin
    lkValid  = 1'b0;
    lkFlags  = '0;
    lkTiming = '0;
    lkCode   = '0;
    if (lkInRange) begin
      lkValid  = entSupp[lkSel];
      lkFlags  = entFlags[lkSel];
      lkTiming = entTim[lkSel];
      lkCode   = entCode[lkSel];
    end
  end

endmodule

// File: rtl/vmode_match_ctrl.sv
module vmode_match_ctrl
  import vmode_match_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             req,
  input  logic             exactHit,
  input  logic             sizeHit,
  output scanStrobe_t      strb,
  output logic [IDX_W-1:0] scanIdx,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  scanState_t       st, stNxt;
  logic [IDX_W-1:0] idx, idxNxt;
  logic             doneR;

  always_comb begin
    stNxt  = st;
    idxNxt = idx;
    strb   = '0;
    unique case (st)
      ST_IDLE: begin
        if (req) begin
          strb.latchQry = 1'b1;
          stNxt         = ST_EXACT;
          idxNxt        = '0;
        end
      end
      ST_EXACT: begin
        if (exactHit) begin
          strb.finHit = 1'b1;
          stNxt       = ST_IDLE;
        end else if (idx == LAST_IDX) begin
          stNxt  = ST_SIZE;
          idxNxt = '0;
        end else begin
          idxNxt = idx + 1'b1;
        end
      end
      ST_SIZE: begin
        if (sizeHit) begin
          strb.finHit = 1'b1;
          stNxt       = ST_IDLE;
        end else if (idx == LAST_IDX) begin
          strb.finMiss = 1'b1;
          stNxt        = ST_IDLE;
        end else begin
          idxNxt = idx + 1'b1;
        end
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      idx   <= '0;
      doneR <= 1'b0;
    end else begin
      st    <= stNxt;
      idx   <= idxNxt;
      doneR <= strb.finHit | strb.finMiss;
    end
  end

  assign scanIdx = idx;
  assign busy    = (st != ST_IDLE);
  assign done    = doneR;

endmodule

// File: rtl/vmode_match.sv
module vmode_match
  import vmode_match_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int HW    = 12,
  parameter int VW    = 12,
  parameter int FW    = 16,
  parameter int RW    = 8,
  parameter int CW    = 8,
  parameter int FLG_W = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TIM_W = 4*HW + 4*VW + FW + RW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrSupp,
  input  logic [FLG_W-1:0]  wrFlags,
  input  logic [TIM_W-1:0]  wrTiming,
  input  logic [CW-1:0]     wrCode,
  input  logic              disEn,
  input  logic [IDX_W-1:0]  disIdx,
  input  logic [IDX_W:0]    lkIdx,
  output logic              lkValid,
  output logic [FLG_W-1:0]  lkFlags,
  output logic [TIM_W-1:0]  lkTiming,
  output logic [CW-1:0]     lkCode,
  input  logic              req,
  input  logic [TIM_W-1:0]  qryTiming,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [CW-1:0]     code
);

  scanStrobe_t      strb;
  logic [IDX_W-1:0] scanIdx;
  logic             exactHit, sizeHit;

  vmode_match_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .req(req),
    .exactHit(exactHit), .sizeHit(sizeHit),
    .strb(strb), .scanIdx(scanIdx), .busy(busy), .done(done)
  );

  vmode_match_dp #(
    .DEPTH(DEPTH), .HW(HW), .VW(VW), .FW(FW), .RW(RW), .CW(CW), .FLG_W(FLG_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrSupp(wrSupp), .wrFlags(wrFlags),
    .wrTiming(wrTiming), .wrCode(wrCode),
    .disEn(disEn), .disIdx(disIdx),
    .lkIdx(lkIdx), .lkValid(lkValid), .lkFlags(lkFlags),
    .lkTiming(lkTiming), .lkCode(lkCode),
    .qryTiming(qryTiming), .strb(strb), .scanIdx(scanIdx),
    .exactHit(exactHit), .sizeHit(sizeHit),
    .resHit(hit), .resCode(code)
  );

endmodule

// File: rtl/vmode_match_chk.sv
module vmode_match_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          req,
  input logic          busy,
  input logic          done,
  input logic          hit,
  input logic [CW-1:0] code
);

  localparam int LIM   = 2*DEPTH;
  localparam int CNT_W = $clog2(LIM + 2);

  logic [CNT_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_done_follows_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && req) |=> busy);

  p_scan_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < CNT_W'(LIM)));

  p_miss_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !hit) |-> (code == '1));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_result_held_r13: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(hit) && $stable(code)));

  p_no_abort_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && req) |=> (busy || done));

endmodule

bind vmode_match vmode_match_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .req(req), .busy(busy),
  .done(done), .hit(hit), .code(code)
);

// File: tb/vmode_match_tb.sv
`timescale 1ns/1ps
module vmode_match_tb_top;

  localparam int DEPTH = 8, HW = 12, VW = 12, FW = 16, RW = 8, CW = 8, FLG_W = 3;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TIM_W = 4*HW + 4*VW + FW + RW;

  logic clk = 1'b0;
  logic rstN;
  logic wrEn, wrSupp, disEn, req;
  logic [IDX_W-1:0] wrIdx, disIdx;
  logic [FLG_W-1:0] wrFlags, lkFlags;
  logic [TIM_W-1:0] wrTiming, lkTiming, qryTiming;
  logic [CW-1:0] wrCode, lkCode, code;
  logic [IDX_W:0] lkIdx;
  logic lkValid, busy, done, hit;

  vmode_match #(.DEPTH(DEPTH), .HW(HW), .VW(VW), .FW(FW), .RW(RW), .CW(CW), .FLG_W(FLG_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrSupp(wrSupp),
    .wrFlags(wrFlags), .wrTiming(wrTiming), .wrCode(wrCode),
    .disEn(disEn), .disIdx(disIdx), .lkIdx(lkIdx), .lkValid(lkValid),
    .lkFlags(lkFlags), .lkTiming(lkTiming), .lkCode(lkCode),
    .req(req), .qryTiming(qryTiming), .busy(busy), .done(done), .hit(hit), .code(code)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // behavioural table model
  bit               mSupp  [DEPTH];
  logic [TIM_W-1:0] mTim   [DEPTH];
  logic [CW-1:0]    mCode  [DEPTH];
  logic [FLG_W-1:0] mFlags [DEPTH];

  function automatic logic [TIM_W-1:0] mkTim(input int ha, hf, hs, hb, va, vf, vs, vb, pix, rate);
    return {RW'(rate), FW'(pix), VW'(vb), VW'(vs), VW'(vf), VW'(va),
            HW'(hb), HW'(hs), HW'(hf), HW'(ha)};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input int idx, input bit s, input logic [FLG_W-1:0] f,
                            input logic [TIM_W-1:0] t, input logic [CW-1:0] c);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = IDX_W'(idx); wrSupp = s; wrFlags = f; wrTiming = t; wrCode = c;
    @(negedge clk);
    wrEn = 1'b0;
    mSupp[idx] = s; mFlags[idx] = f; mTim[idx] = t; mCode[idx] = c;
  endtask

  task automatic disableEntry(input int idx);
    @(negedge clk);
    disEn = 1'b1; disIdx = IDX_W'(idx);
    @(negedge clk);
    disEn = 1'b0;
    mSupp[idx] = 1'b0;
  endtask

  task automatic lookupCheck(input int idx, input string tag);
    bit inR;
    bit expV;
    inR  = (idx < DEPTH);
    expV = inR && mSupp[idx];
    @(negedge clk);
    lkIdx = (IDX_W+1)'(idx);
    #1;
    check(lkValid === expV, {tag, " valid"}, longint'(lkValid), longint'(expV));
    if (inR) begin
      check(lkTiming === mTim[idx], {tag, " timing"}, longint'(lkTiming[63:0]), longint'(mTim[idx][63:0]));
      check(lkFlags === mFlags[idx] && lkCode === mCode[idx], {tag, " flags/code"},
            longint'({lkFlags, lkCode}), longint'({mFlags[idx], mCode[idx]}));
    end else begin
      check(lkTiming === '0 && lkCode === '0 && lkFlags === '0, {tag, " null data"},
            longint'(lkCode), 0);
    end
  endtask

  // expected outcome from the requirements
  task automatic expectSearch(input logic [TIM_W-1:0] q, output bit eh,
                              output logic [CW-1:0] ec, output int lat);
    lat = -1; eh = 1'b0; ec = '1;
    for (int k = 0; k < DEPTH; k++)
      if (lat < 0 && mSupp[k] && mTim[k] == q) begin
        lat = k + 1; eh = 1'b1; ec = mCode[k];
      end
    for (int k = 0; k < DEPTH; k++)
      if (lat < 0 && mSupp[k] && mTim[k][HW-1:0] == q[HW-1:0]
          && mTim[k][4*HW +: VW] == q[4*HW +: VW]) begin
        lat = DEPTH + k + 1; eh = 1'b1; ec = mCode[k];
      end
    if (lat < 0) lat = 2*DEPTH;
  endtask

  task automatic runSearch(input logic [TIM_W-1:0] q, input int injAt,
                           input logic [TIM_W-1:0] injQ, input string tag);
    bit eh;
    logic [CW-1:0] ec;
    int lat;
    expectSearch(q, eh, ec, lat);
    @(negedge clk);
    req = 1'b1; qryTiming = q;
    @(negedge clk);
    req = 1'b0;
    check(busy === 1'b1 && done === 1'b0, {tag, " R11 accept"}, longint'({busy, done}), 2);
    for (int n = 1; n <= lat; n++) begin
      if (n == injAt) begin
        req = 1'b1; qryTiming = injQ;
      end
      @(negedge clk);
      req = 1'b0;
      if (n < lat) begin
        check(busy === 1'b1 && done === 1'b0, {tag, " R11 busy"}, longint'({busy, done}), 2);
      end else begin
        check(done === 1'b1 && busy === 1'b0, {tag, " R11 done cycle"}, longint'({busy, done}), 1);
        check(hit === eh, {tag, " hit"}, longint'(hit), longint'(eh));
        check(code === ec, {tag, " code"}, longint'(code), longint'(ec));
      end
    end
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, {tag, " R13 pulse / R12 no restart"},
          longint'({busy, done}), 0);
    check(hit === eh && code === ec, {tag, " R13 held"}, longint'(code), longint'(ec));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog: act=hung exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [TIM_W-1:0] tA, tB, tB2, tC, tD, tBsz, tE;
    rstN = 1'b0; wrEn = 1'b0; wrSupp = 1'b0; disEn = 1'b0; req = 1'b0;
    wrIdx = '0; disIdx = '0; wrFlags = '0; wrTiming = '0; wrCode = '0;
    lkIdx = '0; qryTiming = '0;
    for (int i = 0; i < DEPTH; i++) begin
      mSupp[i] = 1'b0; mTim[i] = '0; mCode[i] = '0; mFlags[i] = '0;
    end
    tA   = mkTim(640, 16, 96, 48, 480, 10, 2, 33, 2520, 60);
    tB   = mkTim(1280, 110, 40, 220, 720, 5, 5, 20, 7425, 60);
    tB2  = mkTim(1280, 440, 40, 220, 720, 5, 5, 20, 7425, 50);
    tC   = mkTim(1920, 88, 44, 148, 1080, 4, 5, 36, 14850, 60);
    tD   = mkTim(720, 16, 62, 60, 480, 9, 6, 30, 2700, 60);
    tBsz = mkTim(1280, 48, 32, 80, 720, 3, 5, 13, 6400, 60);
    tE   = mkTim(800, 40, 128, 88, 600, 1, 4, 23, 4000, 60);

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && hit === 1'b0, "R1 reset flags",
          longint'({busy, done, hit}), 0);
    check(code === '1, "R1 reset code", longint'(code), 255);
    lookupCheck(0, "R1 reset entry");

    writeEntry(0, 1'b1, 3'b000, tA, 8'd1);
    writeEntry(1, 1'b1, 3'b011, tB, 8'd4);
    writeEntry(2, 1'b1, 3'b111, tC, 8'd16);
    writeEntry(3, 1'b1, 3'b000, tB2, 8'd19);
    writeEntry(4, 1'b1, 3'b100, tB, 8'd47);
    writeEntry(5, 1'b0, 3'b010, tD, 8'd2);

    lookupCheck(1, "R2 lookup written entry");
    lookupCheck(5, "R3 unsupported entry");
    lookupCheck(8, "R3 index at depth");
    lookupCheck(15, "R3 index beyond depth");

    runSearch(tA, 0, '0, "R5 exact entry0");
    runSearch(tB, 0, '0, "R7 lowest of two exact / R6 flags set");
    runSearch(tC, 0, '0, "R6 all flags set");
    runSearch(tB2, 0, '0, "R8 exact beats lower size match");
    runSearch(tBsz, 0, '0, "R8 size pass");
    runSearch(tD, 0, '0, "R9 unsupported skipped / R10 miss");
    runSearch(tE, 0, '0, "R10 miss");

    disableEntry(1);
    lookupCheck(1, "R4 disabled keeps fields");
    runSearch(tB, 0, '0, "R4 disabled entry skipped R9");
    runSearch(tBsz, 0, '0, "R9 size pass skips disabled");

    runSearch(tC, 2, tA, "R12 request while busy");
    runSearch(tD, 5, tA, "R12 request during miss scan");

    writeEntry(5, 1'b1, 3'b010, tD, 8'd2);
    runSearch(tD, 0, '0, "R2 re-enabled entry");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule